// File: doc/BRIEF.md
# Latched-Address Nibble Bus Interface

This block is the host-facing front end of a clock peripheral. It connects a 4-bit data bus, a 4-bit register address and two chip selects to a 16-entry register file. An address latch enable lets it sit on a multiplexed processor bus, where the address and the active-low select are captured when the enable falls. On a plain bus the enable is tied high and the latch stays transparent. All host strobes are asynchronous. They pass through a two-flop synchronizer into the system clock domain, and edges are detected there.

Read and write strobes are decoded into a level read enable and a single-cycle write pulse toward the register file. The tri-state nibble bus is modelled as a data-out vector plus an output enable. The active-high select also acts as a power-fail gate. While it is low, all access is blocked and a clear request goes out to the control bits that must drop in standby.

Top module: `nibble_bus_if`

## Requirements
- R1: With power select high, latched select low, read strobe low and write strobe high, data_oe_o is 1 and data_o equals reg_rdata_i for the register at reg_addr_o, two clock edges after the strobes settle.
- R2: With power select low or latched select high, data_oe_o stays 0 and no write pulse is issued.
- R3: Read and write strobes both low drive nothing and write nothing. A write strobe that rises while the read strobe is still low writes nothing.
- R4: A rising write strobe during a valid access gives exactly one reg_we_o pulse of one cycle, with reg_wdata_o equal to the data bus and reg_addr_o equal to the effective address.
- R5: While the latch enable is high, the effective address and select follow the pins.
- R6: After the latch enable falls, the effective address and select keep their captured values while it stays low, whatever the pins do.
- R7: With the latch enable tied high, every one of the 16 addresses can be written and read back.
- R8: While the power select is low, ctl_clear_o is 1 and the bus is released.
- R9: After reset, data_oe_o and reg_we_o are 0 and ctl_clear_o is 1.

Note on R5 and R6: the latch operates on the synchronized copies of the pins, so the effective address lags the pins by two clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ale_i | input | 1 | Address latch enable, transparent when high |
| addr_i | input | 4 | Register address pins |
| sel_ni | input | 1 | Active-low chip select, latched with the address |
| pwr_sel_i | input | 1 | Active-high select and power-fail gate |
| rd_ni | input | 1 | Read strobe, active low |
| wr_ni | input | 1 | Write strobe, active low, commits on rise |
| data_i | input | 4 | Nibble bus, inbound |
| data_o | output | 4 | Nibble bus, outbound |
| data_oe_o | output | 1 | Bus drive enable |
| reg_addr_o | output | 4 | Effective register address |
| reg_re_o | output | 1 | Register read enable |
| reg_we_o | output | 1 | Register write pulse |
| reg_wdata_o | output | 4 | Register write data |
| reg_rdata_i | input | 4 | Register read data |
| ctl_clear_o | output | 1 | Forces the hold and reset control bits to 0 |

## Verification
Two functions can coincide. A write strobe can rise in the same cycle that the read strobe is still low, and the latch enable can fall while the address pins are already changing. The bench forces the first case by holding both strobes low and then releasing the write strobe first. It judges the result by counting write pulses and reading the register back afterwards. For the second case it changes the pins and the select right after the latch closes, then checks that the access still reaches the captured register.

// File: rtl/nibble_bus_pkg.sv
package nibble_bus_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned DATA_W = 4;

  typedef enum logic [1:0] {
    BUS_IDLE    = 2'd0,
    BUS_READ    = 2'd1,
    BUS_WRITE   = 2'd2,
    BUS_ILLEGAL = 2'd3
  } bus_mode_e;
endpackage

// File: rtl/nib_sync.sv
module nib_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q[i] <= RST_VAL[i];
        sync_q[i] <= RST_VAL[i];
      end else begin
        meta_q[i] <= d_i[i];
        sync_q[i] <= meta_q[i];
      end
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/nib_addr_latch.sv
module nib_addr_latch #(
  parameter int unsigned AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ale_i,
  input  logic [AW-1:0] addr_i,
  input  logic          sel_ni,
  output logic [AW-1:0] addr_o,
  output logic          sel_no
);
  logic [AW-1:0] addr_q;
  logic          sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      sel_q  <= 1'b1;
    end else if (ale_i) begin
      addr_q <= addr_i;
      sel_q  <= sel_ni;
    end
  end

  // transparent while enable high, held value once it drops
  assign addr_o = ale_i ? addr_i : addr_q;
  assign sel_no = ale_i ? sel_ni : sel_q;

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ale_i && $past(!ale_i)) |-> ($stable(addr_q) && $stable(sel_q)));

  p_capture_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_i |=> (addr_q == $past(addr_i) && sel_q == $past(sel_ni)));
endmodule

// File: rtl/nib_strobe_dec.sv
module nib_strobe_dec
  import nibble_bus_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pwr_i,
  input  logic      sel_ni,
  input  logic      rd_ni,
  input  logic      wr_ni,
  output bus_mode_e mode_o,
  output logic      rd_en_o,
  output logic      wr_pulse_o
);
  logic wr_q;
  logic access_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wr_q <= 1'b1;
    else         wr_q <= wr_ni;
  end

  assign access_ok = pwr_i & ~sel_ni;

  always_comb begin
    unique case ({rd_ni, wr_ni})
      2'b01:   mode_o = BUS_READ;
      2'b10:   mode_o = BUS_WRITE;
      2'b00:   mode_o = BUS_ILLEGAL;
      default: mode_o = BUS_IDLE;
    endcase
  end

  assign rd_en_o    = access_ok && (mode_o == BUS_READ);
  // commit on trailing edge; a rise seen while read is low is illegal
  assign wr_pulse_o = access_ok & wr_ni & ~wr_q & rd_ni;

  p_wr_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse_o |=> !wr_pulse_o);

  p_illegal_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_ni && !wr_ni) |-> (!rd_en_o && !wr_pulse_o));

  p_rise_needs_rd_high_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pulse_o |-> rd_ni);
endmodule

// File: rtl/nibble_bus_if.sv
module nibble_bus_if
  import nibble_bus_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ale_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sel_ni,
  input  logic              pwr_sel_i,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  output logic [ADDR_W-1:0] reg_addr_o,
  output logic              reg_re_o,
  output logic              reg_we_o,
  output logic [DATA_W-1:0] reg_wdata_o,
  input  logic [DATA_W-1:0] reg_rdata_i,
  output logic              ctl_clear_o
);
  localparam int unsigned CTL_W = 4;
  localparam int unsigned AS_W  = ADDR_W + 1;

  logic [CTL_W-1:0]  ctl_s;
  logic [AS_W-1:0]   as_s;
  logic [DATA_W-1:0] data_s;
  logic              ale_s, pwr_s, rd_s, wr_s;
  logic              sel_eff;
  logic              rd_en, wr_pulse;
  bus_mode_e         mode;

  // {ale, pwr, rd_n, wr_n}: idle strobes, power low
  nib_sync #(.W(CTL_W), .RST_VAL(4'b1011)) u_sync_ctl (
    .clk_i, .rst_ni, .d_i({ale_i, pwr_sel_i, rd_ni, wr_ni}), .q_o(ctl_s));

  nib_sync #(.W(AS_W), .RST_VAL({1'b1, {ADDR_W{1'b0}}})) u_sync_as (
    .clk_i, .rst_ni, .d_i({sel_ni, addr_i}), .q_o(as_s));

  nib_sync #(.W(DATA_W), .RST_VAL('0)) u_sync_data (
    .clk_i, .rst_ni, .d_i(data_i), .q_o(data_s));

  assign {ale_s, pwr_s, rd_s, wr_s} = ctl_s;

  nib_addr_latch #(.AW(ADDR_W)) u_latch (
    .clk_i, .rst_ni,
    .ale_i  (ale_s),
    .addr_i (as_s[ADDR_W-1:0]),
    .sel_ni (as_s[ADDR_W]),
    .addr_o (reg_addr_o),
    .sel_no (sel_eff));

  nib_strobe_dec u_dec (
    .clk_i, .rst_ni,
    .pwr_i      (pwr_s),
    .sel_ni     (sel_eff),
    .rd_ni      (rd_s),
    .wr_ni      (wr_s),
    .mode_o     (mode),
    .rd_en_o    (rd_en),
    .wr_pulse_o (wr_pulse));

  assign data_oe_o   = rd_en;
  assign data_o      = rd_en ? reg_rdata_i : '0;
  assign reg_re_o    = rd_en;
  assign reg_we_o    = wr_pulse;
  assign reg_wdata_o = data_s;
  assign ctl_clear_o = ~pwr_s;

  p_oe_gated_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> (pwr_s && !sel_eff && mode == BUS_READ));

  p_clear_quiet_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_clear_o |-> (!data_oe_o && !reg_we_o));

  p_we_not_with_oe_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && data_oe_o));
endmodule

// File: tb/tb_nibble_bus_if.sv
module tb_nibble_bus_if;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ale = 1'b1, sel_n = 1'b1, pwr = 1'b0, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0] addr = '0, din = '0;
  logic [3:0] dout, reg_addr, reg_wdata, reg_rdata;
  logic       oe, re, we, clr;
  logic [3:0] mem [16];
  logic [3:0] exp_v [16];
  int         n_chk = 0, n_bad = 0, we_cnt = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  nibble_bus_if dut (
    .clk_i(clk), .rst_ni(rst_n), .ale_i(ale), .addr_i(addr), .sel_ni(sel_n),
    .pwr_sel_i(pwr), .rd_ni(rd_n), .wr_ni(wr_n), .data_i(din),
    .data_o(dout), .data_oe_o(oe), .reg_addr_o(reg_addr), .reg_re_o(re),
    .reg_we_o(we), .reg_wdata_o(reg_wdata), .reg_rdata_i(reg_rdata),
    .ctl_clear_o(clr));

  // register file model behind the interface
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) if (we) begin
    mem[reg_addr] <= reg_wdata;
    we_cnt <= we_cnt + 1;
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(logic [3:0] a, logic [3:0] d, bit set_addr);
    if (set_addr) addr = a;
    din = d;
    wait_n(3);
    wr_n = 1'b0; wait_n(4);
    wr_n = 1'b1; wait_n(5);
  endtask

  task automatic do_read(logic [3:0] a, bit set_addr, output logic [3:0] v, output logic e);
    if (set_addr) addr = a;
    wait_n(3);
    rd_n = 1'b0; wait_n(4);
    v = dout; e = oe;
    rd_n = 1'b1; wait_n(4);
  endtask

  initial begin
    logic [3:0] v;
    logic       e;
    int         c0;
    for (int i = 0; i < 16; i++) begin mem[i] = '0; exp_v[i] = '0; end
    wait_n(3);
    // R9 reset state
    chk("R9 oe", oe, 0); chk("R9 we", we, 0); chk("R9 clr", clr, 1);
    rst_n = 1'b1;
    pwr = 1'b1; sel_n = 1'b0; wait_n(4);
    chk("R8 clr released", clr, 0);

    // R7/R4 sweep with latch enable tied high
    for (int a = 0; a < 16; a++) begin
      c0 = we_cnt;
      exp_v[a] = 4'((a * 5 + 3) & 15);
      do_write(4'(a), exp_v[a], 1);
      chk("R4 one pulse", we_cnt - c0, 1);
    end
    for (int a = 0; a < 16; a++) begin
      do_read(4'(a), 1, v, e);
      chk("R1 oe", e, 1);
      chk("R7 readback", v, exp_v[a]);
    end

    // R5/R6 multiplexed: capture, then disturb pins
    for (int a = 0; a < 16; a += 3) begin
      ale = 1'b1; addr = 4'(a); sel_n = 1'b0; wait_n(4);
      ale = 1'b0; wait_n(1);
      addr = ~4'(a); sel_n = 1'b1;
      exp_v[a] = 4'(15 - a);
      do_write(4'(a), exp_v[a], 0);
      do_read(4'(a), 0, v, e);
      chk("R6 held read", v, exp_v[a]);
      chk("R6 held oe", e, 1);
      ale = 1'b1; addr = 4'(a); wait_n(4);
      do_read(4'(a), 1, v, e);
      chk("R5 transparent sel high", e, 0);
      sel_n = 1'b0;
      do_read(~4'(a), 1, v, e);
      chk("R5 follows pins", v, exp_v[15 - a]);
    end

    // R6: select captured high, pin goes low -> no access
    ale = 1'b1; sel_n = 1'b1; addr = 4'd2; wait_n(4);
    ale = 1'b0; wait_n(1); sel_n = 1'b0;
    c0 = we_cnt;
    do_write(4'd2, 4'd9, 0);
    do_read(4'd2, 0, v, e);
    chk("R6 held sel blocks write", we_cnt - c0, 0);
    chk("R6 held sel blocks read", e, 0);
    ale = 1'b1; wait_n(4);

    // R2 select high write ignored
    sel_n = 1'b1; c0 = we_cnt;
    do_write(4'd4, ~exp_v[4], 1);
    chk("R2 no pulse", we_cnt - c0, 0);
    do_read(4'd4, 1, v, e);
    chk("R2 no drive", e, 0);
    sel_n = 1'b0;
    do_read(4'd4, 1, v, e);
    chk("R2 unchanged", v, exp_v[4]);

    // R8 power low: clear, no read, no write
    pwr = 1'b0; wait_n(4);
    chk("R8 clr", clr, 1);
    c0 = we_cnt;
    do_write(4'd5, ~exp_v[5], 1);
    do_read(4'd5, 1, v, e);
    chk("R8 no drive", e, 0);
    chk("R8 no pulse", we_cnt - c0, 0);
    pwr = 1'b1; wait_n(4);
    do_read(4'd5, 1, v, e);
    chk("R8 unchanged", v, exp_v[5]);

    // R3 both strobes low, write released first
    addr = 4'd7; din = ~exp_v[7]; wait_n(3);
    c0 = we_cnt;
    rd_n = 1'b0; wr_n = 1'b0; wait_n(4);
    chk("R3 no drive", oe, 0);
    wr_n = 1'b1; wait_n(4);
    rd_n = 1'b1; wait_n(4);
    chk("R3 no pulse", we_cnt - c0, 0);
    do_read(4'd7, 1, v, e);
    chk("R3 unchanged", v, exp_v[7]);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule